// File: doc/BRIEF.md
# Reference Lease Lookup and Selection

This block turns the instruction address of a load or store into the lease that a lease-managed cache writes into the line it touches. A table of reference entries is searched in parallel. Each entry pairs a reference address with a primary lease. A hit returns that lease, and a miss returns a configurable fallback lease. The fallback resets to 1, so a line brought in by an unlisted reference can be evicted right after its use.

In each phase, one reference may also carry an alternative lease with a probability threshold. A free-running LFSR supplies a pseudo-random value on each request. When that value is strictly above the threshold and the request hits on that reference, the alternative lease is used in place of the primary one.

A phase controller reloads the block at phase boundaries. It first issues a bulk clear, then writes entries one at a time through an index port, then writes the four phase configuration registers in a single strobe. The cache issues lookups with a single-cycle request strobe, and the answer is combinational in that same cycle.

Top module: `ref_lease_unit`

## Requirements
- R1: After reset, every table entry is invalid and the fallback lease is 1. The alternative probability is all ones, which means the alternative is never chosen. The LFSR holds 16'hACE1.
- R2: When `req_valid` is 1 and `req_ref_addr` equals the key of a valid entry, the block drives `rsp_hit`=1 and `rsp_lease` equal to that entry's primary lease in the same cycle.
- R3: When `req_valid` is 1 and no valid entry matches, the block drives `rsp_hit`=0, `rsp_secondary`=0 and `rsp_lease` equal to the fallback lease register.
- R4: When `req_valid` is 0, `rsp_lease`, `rsp_hit` and `rsp_secondary` are all 0.
- R5: On a hit whose address equals the alternative reference register, `rsp_lease` is the alternative lease and `rsp_secondary`=1 if the current LFSR value is strictly greater than the probability register. Otherwise the primary lease is returned with `rsp_secondary`=0. Equal values select the primary lease. Hits on any other reference never select the alternative.
- R6: The LFSR is 16 bits wide. Its next value is {q[14:0], q[15]^q[13]^q[12]^q[10]}. It advances exactly once at the end of each cycle with `req_valid`=1 and holds otherwise. The comparison in R5 uses the value before that advance.
- R7: A write with `tbl_we`=1 stores `tbl_key`/`tbl_lease` into entry `tbl_idx` and marks the entry valid. A lookup in the same cycle still sees the old contents. The new entry is visible from the next cycle.
- R8: `tbl_clear`=1 invalidates every entry from the next cycle. A table write in the same cycle is dropped.
- R9: `cfg_we`=1 loads the fallback lease, alternative reference, alternative lease and probability together. All four take effect from the next cycle.
- R10: If several valid entries share a key, the entry with the lowest index supplies the primary lease.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_ref_addr | input | ADDR_W | Instruction address of the accessing reference |
| rsp_lease | output | LEASE_W | Selected lease |
| rsp_hit | output | 1 | Reference found in table |
| rsp_secondary | output | 1 | Alternative lease was selected |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_key | input | ADDR_W | Reference address stored as key |
| tbl_lease | input | LEASE_W | Primary lease stored in entry |
| tbl_clear | input | 1 | Invalidate all entries |
| cfg_we | input | 1 | Phase configuration write strobe |
| cfg_dflt_lease | input | LEASE_W | Fallback lease for misses |
| cfg_sec_ref | input | ADDR_W | Reference that owns the alternative lease |
| cfg_sec_lease | input | LEASE_W | Alternative lease value |
| cfg_sec_prob | input | 16 | Probability threshold |

## Verification
All lookup results are combinational, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples 5 ns later, well before the next rising edge. Table, clear and configuration writes take effect one rising edge after the strobe. Each is checked by a lookup issued on the following falling edge, and also by a lookup issued together with the strobe to show the old state still applies. The LFSR steps on the rising edge that closes each request cycle. The bench keeps its own model of the LFSR, advances it once per issued request after sampling, and derives every expected alternative-versus-primary choice from that model.

// File: rtl/lease_pkg.sv
`timescale 1ns/1ps
package lease_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // Fibonacci step, taps 16,14,13,11
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/lease_entry.sv
`timescale 1ns/1ps
module lease_entry #(
    parameter int ADDR_W  = 32,
    parameter int LEASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_key,
    input  logic [LEASE_W-1:0] wr_lease,
    input  logic [ADDR_W-1:0]  look_addr,
    output logic               hit,
    output logic [LEASE_W-1:0] lease
);
    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  key;
        logic [LEASE_W-1:0] lease;
    } entry_t;

    entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (clr) begin
            ent_d.valid = 1'b0;
        end else if (wr_en) begin
            ent_d.valid = 1'b1;
            ent_d.key   = wr_key;
            ent_d.lease = wr_lease;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign hit   = ent_q.valid && (ent_q.key == look_addr);
    assign lease = ent_q.lease;
endmodule

// File: rtl/lease_table.sv
`timescale 1ns/1ps
module lease_table #(
    parameter int ADDR_W  = 32,
    parameter int LEASE_W = 16,
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_key,
    input  logic [LEASE_W-1:0] wr_lease,
    input  logic [ADDR_W-1:0]  look_addr,
    output logic               any_hit,
    output logic [LEASE_W-1:0] prim_lease
);
    logic [ENTRIES-1:0] hit_vec;
    logic [LEASE_W-1:0] lease_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        lease_entry #(.ADDR_W(ADDR_W), .LEASE_W(LEASE_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .wr_en     (wr_en && (wr_idx == IDX_W'(g))),
            .wr_key    (wr_key),
            .wr_lease  (wr_lease),
            .look_addr (look_addr),
            .hit       (hit_vec[g]),
            .lease     (lease_arr[g])
        );
    end

    // lowest matching index wins
    always_comb begin
        prim_lease = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) prim_lease = lease_arr[i];
        end
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/lease_lfsr.sv
`timescale 1ns/1ps
module lease_lfsr
    import lease_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] value
);
    logic [LFSR_W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) state_d = lfsr_next(state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LFSR_SEED;
        else        state_q <= state_d;
    end

    assign value = state_q;
endmodule

// File: rtl/lease_cfg.sv
`timescale 1ns/1ps
module lease_cfg #(
    parameter int ADDR_W  = 32,
    parameter int LEASE_W = 16,
    parameter int PROB_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [LEASE_W-1:0] dflt_in,
    input  logic [ADDR_W-1:0]  sref_in,
    input  logic [LEASE_W-1:0] slease_in,
    input  logic [PROB_W-1:0]  prob_in,
    output logic [LEASE_W-1:0] dflt_q,
    output logic [ADDR_W-1:0]  sref_q,
    output logic [LEASE_W-1:0] slease_q,
    output logic [PROB_W-1:0]  prob_q
);
    typedef struct packed {
        logic [LEASE_W-1:0] dflt;
        logic [ADDR_W-1:0]  sref;
        logic [LEASE_W-1:0] slease;
        logic [PROB_W-1:0]  prob;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.dflt   = dflt_in;
            cfg_d.sref   = sref_in;
            cfg_d.slease = slease_in;
            cfg_d.prob   = prob_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.dflt   <= LEASE_W'(1);
            cfg_q.sref   <= '0;
            cfg_q.slease <= '0;
            cfg_q.prob   <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dflt_q   = cfg_q.dflt;
    assign sref_q   = cfg_q.sref;
    assign slease_q = cfg_q.slease;
    assign prob_q   = cfg_q.prob;
endmodule

// File: rtl/ref_lease_unit.sv
`timescale 1ns/1ps
module ref_lease_unit
    import lease_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEASE_W = 16,
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_ref_addr,
    output logic [LEASE_W-1:0] rsp_lease,
    output logic               rsp_hit,
    output logic               rsp_secondary,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [ADDR_W-1:0]  tbl_key,
    input  logic [LEASE_W-1:0] tbl_lease,
    input  logic               tbl_clear,
    input  logic               cfg_we,
    input  logic [LEASE_W-1:0] cfg_dflt_lease,
    input  logic [ADDR_W-1:0]  cfg_sec_ref,
    input  logic [LEASE_W-1:0] cfg_sec_lease,
    input  logic [LFSR_W-1:0]  cfg_sec_prob
);
    logic               tbl_hit;
    logic [LEASE_W-1:0] prim_lease;
    logic [LEASE_W-1:0] dflt_lease_q;
    logic [ADDR_W-1:0]  sec_ref_q;
    logic [LEASE_W-1:0] sec_lease_q;
    logic [LFSR_W-1:0]  sec_prob_q;
    logic [LFSR_W-1:0]  lfsr_q;
    logic               take_sec;

    lease_table #(.ADDR_W(ADDR_W), .LEASE_W(LEASE_W), .ENTRIES(ENTRIES)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tbl_clear),
        .wr_en      (tbl_we),
        .wr_idx     (tbl_idx),
        .wr_key     (tbl_key),
        .wr_lease   (tbl_lease),
        .look_addr  (req_ref_addr),
        .any_hit    (tbl_hit),
        .prim_lease (prim_lease)
    );

    lease_cfg #(.ADDR_W(ADDR_W), .LEASE_W(LEASE_W), .PROB_W(LFSR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .dflt_in   (cfg_dflt_lease),
        .sref_in   (cfg_sec_ref),
        .slease_in (cfg_sec_lease),
        .prob_in   (cfg_sec_prob),
        .dflt_q    (dflt_lease_q),
        .sref_q    (sec_ref_q),
        .slease_q  (sec_lease_q),
        .prob_q    (sec_prob_q)
    );

    lease_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (req_valid),
        .value (lfsr_q)
    );

    always_comb begin
        take_sec = tbl_hit && (req_ref_addr == sec_ref_q) && (lfsr_q > sec_prob_q);
        if (!req_valid)    rsp_lease = '0;
        else if (!tbl_hit) rsp_lease = dflt_lease_q;
        else if (take_sec) rsp_lease = sec_lease_q;
        else               rsp_lease = prim_lease;
        rsp_hit       = req_valid && tbl_hit;
        rsp_secondary = req_valid && take_sec;
    end
endmodule

// File: rtl/ref_lease_unit_chk.sv
`timescale 1ns/1ps
module ref_lease_unit_chk #(
    parameter int ADDR_W  = 32,
    parameter int LEASE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_ref_addr,
    input logic [LEASE_W-1:0] rsp_lease,
    input logic               rsp_hit,
    input logic               rsp_secondary,
    input logic               tbl_clear,
    input logic               cfg_we,
    input logic [LEASE_W-1:0] cfg_dflt_lease,
    input logic [LEASE_W-1:0] dflt_lease_q,
    input logic [ADDR_W-1:0]  sec_ref_q,
    input logic [LEASE_W-1:0] sec_lease_q,
    input logic [15:0]        lfsr_q
);
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (rsp_lease == '0 && !rsp_hit && !rsp_secondary));
    // R3
    miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_hit) |-> (rsp_lease == dflt_lease_q && !rsp_secondary));
    // R5
    sec_only_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_secondary |-> (rsp_hit && req_ref_addr == sec_ref_q && rsp_lease == sec_lease_q));
    // R6
    lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (lfsr_q != $past(lfsr_q)));
    // R6
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(lfsr_q));
    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0);
    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clear |=> !rsp_hit);
    // R9
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (dflt_lease_q == $past(cfg_dflt_lease)));
endmodule

bind ref_lease_unit ref_lease_unit_chk #(.ADDR_W(ADDR_W), .LEASE_W(LEASE_W)) u_chk (.*);

// File: tb/ref_lease_unit_bench.sv
`timescale 1ns/1ps
module ref_lease_unit_bench;
    localparam int ADDR_W  = 32;
    localparam int LEASE_W = 16;
    localparam int ENTRIES = 128;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [ADDR_W-1:0]  req_ref_addr = '0;
    logic [LEASE_W-1:0] rsp_lease;
    logic               rsp_hit;
    logic               rsp_secondary;
    logic               tbl_we = 1'b0;
    logic [IDX_W-1:0]   tbl_idx = '0;
    logic [ADDR_W-1:0]  tbl_key = '0;
    logic [LEASE_W-1:0] tbl_lease = '0;
    logic               tbl_clear = 1'b0;
    logic               cfg_we = 1'b0;
    logic [LEASE_W-1:0] cfg_dflt_lease = '0;
    logic [ADDR_W-1:0]  cfg_sec_ref = '0;
    logic [LEASE_W-1:0] cfg_sec_lease = '0;
    logic [15:0]        cfg_sec_prob = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] lfsr_m = 16'hACE1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ref_lease_unit #(.ADDR_W(ADDR_W), .LEASE_W(LEASE_W), .ENTRIES(ENTRIES)) u_ref_lease_unit (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [15:0] lease;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h1000, 1'b1, 16'd10},
        '{32'h1004, 1'b1, 16'd20},
        '{32'h2000, 1'b1, 16'd300},
        '{32'h3FFC, 1'b1, 16'hFFFF},
        '{32'h1008, 1'b0, 16'd1},
        '{32'h0000, 1'b0, 16'd1},
        '{32'h2004, 1'b0, 16'd1},
        '{32'h1000, 1'b1, 16'd10}
    };

    function automatic logic [15:0] step_m(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; tbl_we = 1'b0; tbl_clear = 1'b0; cfg_we = 1'b0;
    endtask

    // one request cycle; checks sampled mid-low-phase, then model steps
    task automatic look(input string tag, input logic [31:0] a,
                        input logic eh, input logic [15:0] el, input logic es);
        @(negedge clk);
        req_valid = 1'b1; req_ref_addr = a;
        #5;
        chk({tag, " hit"}, 32'(rsp_hit), 32'(eh));
        chk({tag, " lease"}, 32'(rsp_lease), 32'(el));
        chk({tag, " sec"}, 32'(rsp_secondary), 32'(es));
        lfsr_m = step_m(lfsr_m);
        idle();
    endtask

    task automatic wr(input int idx, input logic [31:0] key, input logic [15:0] ls);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IDX_W'(idx); tbl_key = key; tbl_lease = ls;
        idle();
    endtask

    task automatic cfg(input logic [15:0] d, input logic [31:0] r,
                       input logic [15:0] sl, input logic [15:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dflt_lease = d; cfg_sec_ref = r; cfg_sec_lease = sl; cfg_sec_prob = p;
        idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 idle outputs
        #5;
        chk("R4 idle lease", 32'(rsp_lease), 0);
        chk("R4 idle hit", 32'(rsp_hit), 0);
        // R1 reset: empty table, fallback 1
        look("R1 reset lookup", 32'h1000, 1'b0, 16'd1, 1'b0);

        wr(0, 32'h1000, 16'd10);
        wr(1, 32'h1004, 16'd20);
        wr(5, 32'h2000, 16'd300);
        wr(127, 32'h3FFC, 16'hFFFF);
        wr(7, 32'h1000, 16'd99);   // R10 duplicate at higher index
        for (int i = 0; i < 8; i++) begin
            look(VECS[i].hit ? "R2/R10 vec" : "R3 vec", VECS[i].addr,
                 VECS[i].hit, VECS[i].lease, 1'b0);
        end

        // R7 same-cycle write and lookup sees old contents
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IDX_W'(2); tbl_key = 32'h5000; tbl_lease = 16'd77;
        req_valid = 1'b1; req_ref_addr = 32'h5000;
        #5;
        chk("R7 old contents hit", 32'(rsp_hit), 0);
        chk("R7 old contents lease", 32'(rsp_lease), 1);
        lfsr_m = step_m(lfsr_m);
        idle();
        look("R7 new entry", 32'h5000, 1'b1, 16'd77, 1'b0);

        // R9 / R5 alternative lease with half probability
        cfg(16'd5, 32'h1004, 16'd4444, 16'h7FFF);
        look("R9 new fallback", 32'h7777, 1'b0, 16'd5, 1'b0);
        for (int i = 0; i < 24; i++) begin
            logic s;
            s = (lfsr_m > 16'h7FFF);
            look("R5/R6 alt draw", 32'h1004, 1'b1, s ? 16'd4444 : 16'd20, s);
            // R5 other references never take the alternative
            look("R5 non-owner", 32'h1000, 1'b1, 16'd10, 1'b0);
        end
        // R6 idle cycles must not advance the LFSR
        repeat (5) idle();
        cfg(16'd5, 32'h1004, 16'd4444, lfsr_m);
        look("R5 equal primary", 32'h1004, 1'b1, 16'd20, 1'b0);
        cfg(16'd5, 32'h1004, 16'd4444, 16'h0000);
        look("R5 zero prob alt", 32'h1004, 1'b1, 16'd4444, 1'b1);

        // R8 clear drops a same-cycle write
        @(negedge clk);
        tbl_clear = 1'b1; tbl_we = 1'b1; tbl_idx = IDX_W'(3); tbl_key = 32'h6000; tbl_lease = 16'd55;
        idle();
        look("R8 cleared", 32'h1000, 1'b0, 16'd5, 1'b0);
        look("R8 dropped write", 32'h6000, 1'b0, 16'd5, 1'b0);
        look("R8 alt ref cleared", 32'h1004, 1'b0, 16'd5, 1'b0);

        summary();
    end
endmodule